// File: doc/BRIEF.md
# Pixel Serializer and Colour Mapper

This block turns the display bytes of a video controller into a stream of 8-bit physical colours, one for each pixel clock. Once per memory cycle of sixteen pixel clocks a fetch stage hands it two bytes with a load strobe. The block then plays those bytes out over the next sixteen clocks. It packs 1, 2, 4 or 8 bits into each pixel, depending on the colour mode captured with the bytes, so one group holds 16, 8, 4 or 2 pixels.

Every pixel index passes through a small logical palette. Indices 0 to 7 select one of eight 8-bit slots that are reloaded for each modeline. Indices 8 to 15 are built from a 5-bit bias value and the low three index bits. In 2-colour mode, optional flags use the top bit or the bottom bit of each byte to switch to an alternate colour pair. A 4-bit external colour source can replace the internal pixel under one of four priority rules. Groups that fall outside a margin window, counted in groups from the start of the line, show the border colour, and so does any clock with blanking asserted.

Top module: `pixel_colour_engine`

## Requirements
- R1: While reset is asserted `colour_o` is 0. After reset, and before the first load, the output shows `border_i`.
- R2: Colour mode 0 (2-colour) gives 16 one-clock pixels. Byte A comes first, then byte B, each sent MSB first. A bit of 1 selects logical colour 1 and a bit of 0 selects logical colour 0.
- R3: Colour mode 1 (4-colour) gives 8 pixels of two clocks each, four from byte A and then four from byte B. The pixel indices, in order, are {d7,d3}, {d6,d2}, {d5,d1} and {d4,d0}, with the first bit named being the index MSB.
- R4: Colour mode 2 (16-colour) gives 4 pixels of four clocks each, two from byte A and then two from byte B. The indices are {d7,d5,d3,d1} and then {d6,d4,d2,d0}.
- R5: Colour mode 3 (256-colour) gives 2 pixels of eight clocks each. Each pixel is byte A and then byte B, used directly as the physical colour without the palette.
- R6: Logical index i in 0..7 maps to `palette_i[8*i+7:8*i]`. Index 8..15 maps to {`bias_i`, index[2:0]}.
- R7: When the top-bit flag is captured with a 2-colour group, a byte whose bit 7 is 1 uses logical colours 2 and 3 instead of 0 and 1. Bit 7 of every byte is shifted out as 0 while the flag is set.
- R8: When the bottom-bit flag is captured with a 2-colour group, a byte whose bit 0 is 1 uses logical colours 4 and 5. Bit 0 is shifted out as 0 while the flag is set. If both flags select a pair for the same byte, the top-bit pair (2 and 3) wins.
- R9: In the active window with `ext_req_i` high, the external index, mapped through R6, replaces the internal colour when `ext_prio_i` allows it. Code 0 always allows it. Code 1 allows it only if the internal index is 8..15. Code 2 also allows it if `ext_col_i[3]` is 0. Code 3 also allows it if `ext_col_i[2]` is 0. In 256-colour mode the internal index never counts as 8..15.
- R10: Groups are numbered from 0 at a load that has `line_start_i` high, and the number rises by one per load. A group is active only if lo <= number < hi, with the margins sampled at its load. An inactive group outputs `border_i`.
- R11: A pixel clock with `blank_i` high outputs `border_i`.
- R12: A load restarts the pixel phase at 0. The colour for phase p appears on `colour_o` one clock after the clock in which that phase is current. Mode, alternate flags and margins are captured at the load. Palette, bias, border, blanking and external inputs are used live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture a new pair of display bytes |
| line_start_i | input | 1 | This load is group 0 of a scanline |
| byte_a_i | input | 8 | First display byte of the group |
| byte_b_i | input | 8 | Second display byte of the group |
| mode_i | input | 2 | Colour mode: 0=2, 1=4, 2=16, 3=256 colours |
| msb_alt_i | input | 1 | Top-bit alternate pair enable |
| lsb_alt_i | input | 1 | Bottom-bit alternate pair enable |
| margin_lo_i | input | MARGIN_W | First active group number |
| margin_hi_i | input | MARGIN_W | First inactive group number after the window |
| palette_i | input | 64 | Eight logical colour slots, slot i in bits 8i+7..8i |
| bias_i | input | 5 | High bits of logical colours 8..15 |
| border_i | input | 8 | Border colour |
| blank_i | input | 1 | Blanking, forces border |
| ext_req_i | input | 1 | External colour request |
| ext_col_i | input | 4 | External logical colour index |
| ext_prio_i | input | 2 | External priority rule |
| colour_o | output | 8 | Registered physical colour |

## Verification
The assertions assume that a group is not reloaded before its phase counter is checked, and that control inputs are stable at the clock edge. They also assume that palette, bias and border hold steady within any cycle in which a property compares the output with them. The bench drives every input on the falling edge and holds the palette, bias, border and priority steady through each group. While a group plays out, it scrambles the captured controls (mode, flags, margins) at random to show that they are held. External requests, external colours and blanking change per pixel from seeded random draws, and directed groups cover each mode, each alternate-flag case, each priority code and the exact margin edges.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    localparam int COL_W    = 8;
    localparam int NUM_LOG  = 8;
    localparam int PHASES   = 16;
    localparam int PHASE_W  = $clog2(PHASES);
    localparam int BIAS_W   = 5;

    typedef enum logic [1:0] {
        CM_2   = 2'd0,
        CM_4   = 2'd1,
        CM_16  = 2'd2,
        CM_256 = 2'd3
    } cmode_e;

    typedef struct packed {
        logic [COL_W-1:0] idx;
        logic             direct;
        logic             active;
    } pix_t;

endpackage

// File: rtl/pxs_serializer.sv
module pxs_serializer
    import pxs_pkg::*;
#(
    parameter int MARGIN_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                line_start_i,
    input  logic [COL_W-1:0]    byte_a_i,
    input  logic [COL_W-1:0]    byte_b_i,
    input  logic [1:0]          mode_i,
    input  logic                msb_alt_i,
    input  logic                lsb_alt_i,
    input  logic [MARGIN_W-1:0] margin_lo_i,
    input  logic [MARGIN_W-1:0] margin_hi_i,
    output pix_t                pix_o
);

    typedef struct packed {
        logic [COL_W-1:0]    a;
        logic [COL_W-1:0]    b;
        logic [PHASE_W-1:0]  phase;
        cmode_e              mode;
        logic                msb_alt;
        logic                lsb_alt;
        logic                active;
        logic [MARGIN_W-1:0] grp;
    } ser_st_t;

    ser_st_t             st_d, st_q;
    logic [MARGIN_W-1:0] grp_cur;
    logic [COL_W-1:0]    cur_byte;
    logic [COL_W-1:0]    eff_byte;
    logic [2:0]          alt_base;
    logic [1:0]          sel4;
    logic                sel16;

    // next-state: group numbering, capture at load, phase advance
    always_comb begin
        st_d     = st_q;
        grp_cur  = line_start_i ? '0 : st_q.grp;
        st_d.grp = grp_cur;
        st_d.phase = st_q.phase + 1'b1;
        if (load_i) begin
            st_d.a       = byte_a_i;
            st_d.b       = byte_b_i;
            st_d.phase   = '0;
            st_d.mode    = cmode_e'(mode_i);
            st_d.msb_alt = msb_alt_i;
            st_d.lsb_alt = lsb_alt_i;
            st_d.active  = (grp_cur >= margin_lo_i) && (grp_cur < margin_hi_i);
            st_d.grp     = grp_cur + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // pixel decode: in every mode the second half of the group uses byte B
    always_comb begin
        cur_byte = st_q.phase[PHASE_W-1] ? st_q.b : st_q.a;
        eff_byte = cur_byte;
        alt_base = 3'd0;
        sel4     = st_q.phase[2:1];
        sel16    = st_q.phase[2];
        pix_o    = '0;
        pix_o.active = st_q.active;
        pix_o.direct = (st_q.mode == CM_256);
        unique case (st_q.mode)
            CM_2: begin
                if (st_q.msb_alt && cur_byte[7])      alt_base = 3'd2;
                else if (st_q.lsb_alt && cur_byte[0]) alt_base = 3'd4;
                if (st_q.msb_alt) eff_byte[7] = 1'b0;
                if (st_q.lsb_alt) eff_byte[0] = 1'b0;
                pix_o.idx = {5'd0, alt_base}
                          + {7'd0, eff_byte[3'd7 - st_q.phase[2:0]]};
            end
            CM_4: begin
                pix_o.idx = {6'd0,
                             cur_byte[3'd7 - {1'b0, sel4}],
                             cur_byte[3'd3 - {1'b0, sel4}]};
            end
            CM_16: begin
                pix_o.idx = {4'd0,
                             cur_byte[3'd7 - {2'b0, sel16}],
                             cur_byte[3'd5 - {2'b0, sel16}],
                             cur_byte[3'd3 - {2'b0, sel16}],
                             cur_byte[3'd1 - {2'b0, sel16}]};
            end
            default: begin
                pix_o.idx = cur_byte;
            end
        endcase
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.phase == '0)); // R12

    AST_FOUR_COLOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CM_4) |-> (pix_o.idx < 8'd4)); // R3

    AST_TWO_COLOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CM_2) |-> (pix_o.idx < 8'd6)); // R2

    AST_MSB_ALT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CM_2 && st_q.msb_alt && cur_byte[7] && st_q.phase[2:0] == 3'd0)
        |-> (pix_o.idx == 8'd2)); // R7

    AST_LSB_ALT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CM_2 && st_q.lsb_alt && cur_byte[0]
         && !(st_q.msb_alt && cur_byte[7]) && st_q.phase[2:0] == 3'd7)
        |-> (pix_o.idx == 8'd4)); // R8

endmodule

// File: rtl/pxs_colour_map.sv
module pxs_colour_map
    import pxs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  pix_t                   pix_i,
    input  logic [NUM_LOG*COL_W-1:0] palette_i,
    input  logic [BIAS_W-1:0]      bias_i,
    input  logic [COL_W-1:0]       border_i,
    input  logic                   blank_i,
    input  logic                   ext_req_i,
    input  logic [3:0]             ext_col_i,
    input  logic [1:0]             ext_prio_i,
    output logic [COL_W-1:0]       col_o
);

    localparam int SEL_W = $clog2(NUM_LOG);

    logic [COL_W-1:0] slot [NUM_LOG];
    logic [COL_W-1:0] int_col;
    logic [COL_W-1:0] ext_phys;
    logic             int_high;
    logic             prio_ok;
    logic             ext_win;

    genvar g;
    generate
        for (g = 0; g < NUM_LOG; g++) begin : g_slot
            assign slot[g] = palette_i[g*COL_W +: COL_W];
        end
    endgenerate

    always_comb begin
        int_high = !pix_i.direct && pix_i.idx[SEL_W];
        if (pix_i.direct)          int_col = pix_i.idx;
        else if (pix_i.idx[SEL_W]) int_col = {bias_i, pix_i.idx[SEL_W-1:0]};
        else                       int_col = slot[pix_i.idx[SEL_W-1:0]];

        ext_phys = ext_col_i[3] ? {bias_i, ext_col_i[2:0]} : slot[ext_col_i[2:0]];

        unique case (ext_prio_i)
            2'd0:    prio_ok = 1'b1;
            2'd1:    prio_ok = int_high;
            2'd2:    prio_ok = int_high || !ext_col_i[3];
            default: prio_ok = int_high || !ext_col_i[2];
        endcase
        ext_win = ext_req_i && prio_ok;

        if (!pix_i.active || blank_i) col_o = border_i;
        else if (ext_win)             col_o = ext_phys;
        else                          col_o = int_col;
    end

    AST_BIAS_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_i.active && !blank_i && !ext_win && !pix_i.direct && pix_i.idx[SEL_W])
        |-> (col_o[COL_W-1:COL_W-BIAS_W] == bias_i)); // R6

    AST_EXT_ALWAYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_i.active && !blank_i && ext_req_i && ext_prio_i == 2'd0 && ext_col_i[3])
        |-> (col_o == {bias_i, ext_col_i[2:0]})); // R9

endmodule

// File: rtl/pixel_colour_engine.sv
module pixel_colour_engine
    import pxs_pkg::*;
#(
    parameter int MARGIN_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                line_start_i,
    input  logic [7:0]          byte_a_i,
    input  logic [7:0]          byte_b_i,
    input  logic [1:0]          mode_i,
    input  logic                msb_alt_i,
    input  logic                lsb_alt_i,
    input  logic [MARGIN_W-1:0] margin_lo_i,
    input  logic [MARGIN_W-1:0] margin_hi_i,
    input  logic [63:0]         palette_i,
    input  logic [4:0]          bias_i,
    input  logic [7:0]          border_i,
    input  logic                blank_i,
    input  logic                ext_req_i,
    input  logic [3:0]          ext_col_i,
    input  logic [1:0]          ext_prio_i,
    output logic [7:0]          colour_o
);

    typedef struct packed {
        logic [COL_W-1:0] colour;
    } out_st_t;

    pix_t             pix;
    logic [COL_W-1:0] mapped;
    out_st_t          out_d, out_q;

    pxs_serializer #(.MARGIN_W(MARGIN_W)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .line_start_i (line_start_i),
        .byte_a_i     (byte_a_i),
        .byte_b_i     (byte_b_i),
        .mode_i       (mode_i),
        .msb_alt_i    (msb_alt_i),
        .lsb_alt_i    (lsb_alt_i),
        .margin_lo_i  (margin_lo_i),
        .margin_hi_i  (margin_hi_i),
        .pix_o        (pix)
    );

    pxs_colour_map u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_i      (pix),
        .palette_i  (palette_i),
        .bias_i     (bias_i),
        .border_i   (border_i),
        .blank_i    (blank_i),
        .ext_req_i  (ext_req_i),
        .ext_col_i  (ext_col_i),
        .ext_prio_i (ext_prio_i),
        .col_o      (mapped)
    );

    always_comb begin
        out_d        = out_q;
        out_d.colour = mapped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign colour_o = out_q.colour;

    AST_BLANK_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> (colour_o == $past(border_i))); // R11

    AST_IDLE_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix.active) |=> (colour_o == $past(border_i))); // R10

endmodule

// File: tb/pixel_colour_engine_tb.sv
module pixel_colour_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        line_start_i = 1'b0;
    logic [7:0]  byte_a_i = '0;
    logic [7:0]  byte_b_i = '0;
    logic [1:0]  mode_i = '0;
    logic        msb_alt_i = 1'b0;
    logic        lsb_alt_i = 1'b0;
    logic [5:0]  margin_lo_i = '0;
    logic [5:0]  margin_hi_i = '0;
    logic [63:0] palette_i = '0;
    logic [4:0]  bias_i = '0;
    logic [7:0]  border_i = '0;
    logic        blank_i = 1'b0;
    logic        ext_req_i = 1'b0;
    logic [3:0]  ext_col_i = '0;
    logic [1:0]  ext_prio_i = '0;
    logic [7:0]  colour_o;

    int checks = 0;
    int fails  = 0;
    int grp_tb = 0;
    logic [5:0] lo_r = 6'd0;
    logic [5:0] hi_r = 6'd63;

    pixel_colour_engine u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .line_start_i(line_start_i),
        .byte_a_i(byte_a_i), .byte_b_i(byte_b_i), .mode_i(mode_i),
        .msb_alt_i(msb_alt_i), .lsb_alt_i(lsb_alt_i),
        .margin_lo_i(margin_lo_i), .margin_hi_i(margin_hi_i),
        .palette_i(palette_i), .bias_i(bias_i), .border_i(border_i),
        .blank_i(blank_i), .ext_req_i(ext_req_i), .ext_col_i(ext_col_i),
        .ext_prio_i(ext_prio_i), .colour_o(colour_o)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] map_log(input logic [3:0] idx);
        if (idx >= 4'd8) return {bias_i, idx[2:0]};
        return palette_i[int'(idx[2:0])*8 +: 8];
    endfunction

    function automatic logic [7:0] expect_colour(
        input logic [7:0] a, input logic [7:0] b, input logic [1:0] md,
        input logic ma, input logic la, input int p, input logic act,
        output string why);
        logic [7:0] byt;
        logic [7:0] idx;
        logic [7:0] ic;
        logic       hi;
        logic       win;
        logic       bitv;
        int         k;
        int         j;
        int         pos;
        byt = (p < 8) ? a : b;
        idx = '0;
        case (md)
            2'd0: begin
                pos  = 7 - (p % 8);
                bitv = byt[pos];
                if (ma && pos == 7) bitv = 1'b0;
                if (la && pos == 0) bitv = 1'b0;
                if (ma && byt[7])      idx = 8'd2 + {7'd0, bitv};
                else if (la && byt[0]) idx = 8'd4 + {7'd0, bitv};
                else                   idx = {7'd0, bitv};
            end
            2'd1: begin
                k = p / 2; j = k % 4;
                idx = {6'd0, byt[7-j], byt[3-j]};
            end
            2'd2: begin
                k = p / 4; j = k % 2;
                idx = {4'd0, byt[7-j], byt[5-j], byt[3-j], byt[1-j]};
            end
            default: idx = byt;
        endcase
        ic = (md == 2'd3) ? idx : map_log(idx[3:0]);
        hi = (md != 2'd3) && (idx >= 8'd8);
        case (ext_prio_i)
            2'd0: win = 1'b1;
            2'd1: win = hi;
            2'd2: win = hi || !ext_col_i[3];
            default: win = hi || !ext_col_i[2];
        endcase
        if (blank_i)                  begin why = "R11"; return border_i; end
        if (!act)                     begin why = "R10"; return border_i; end
        if (ext_req_i && win)         begin why = "R9";  return map_log(ext_col_i); end
        why = "";
        return ic;
    endfunction

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: colour_o got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // plays one group; ext_pct / blank_pct are percentages per pixel
    task automatic run_group(input logic [7:0] a, input logic [7:0] b,
                             input logic [1:0] md, input logic ma, input logic la,
                             input logic ls, input int ext_pct, input int blank_pct,
                             input string tag);
        logic       act;
        logic [7:0] exp;
        string      why;
        @(negedge clk);
        if (ls) grp_tb = 0;
        act = (grp_tb >= int'(lo_r)) && (grp_tb < int'(hi_r));
        grp_tb++;
        load_i = 1'b1; line_start_i = ls; byte_a_i = a; byte_b_i = b;
        mode_i = md; msb_alt_i = ma; lsb_alt_i = la;
        margin_lo_i = lo_r; margin_hi_i = hi_r;
        ext_req_i = 1'b0; blank_i = 1'b0;
        @(posedge clk);
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            load_i = 1'b0; line_start_i = 1'b0;
            // captured controls scrambled while the group plays (R12)
            mode_i = 2'($urandom); msb_alt_i = 1'($urandom); lsb_alt_i = 1'($urandom);
            margin_lo_i = 6'($urandom); margin_hi_i = 6'($urandom);
            byte_a_i = 8'($urandom); byte_b_i = 8'($urandom);
            ext_req_i = (int'($urandom % 100) < ext_pct);
            ext_col_i = 4'($urandom);
            blank_i   = (int'($urandom % 100) < blank_pct);
            exp = expect_colour(a, b, md, ma, la, p, act, why);
            @(posedge clk);
            #1;
            check8((why == "") ? tag : why, colour_o, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) palette_i[i*8 +: 8] = 8'(8'h11 * (i + 1) + 8'h03);
        bias_i = 5'b10110;
        border_i = 8'h5A;
        #20;
        check8("R1", colour_o, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check8("R1", colour_o, 8'h5A);

        run_group(8'h3A, 8'hC5, 2'd0, 1'b0, 1'b0, 1'b1, 0, 0, "R12");
        run_group(8'hA5, 8'h3C, 2'd0, 1'b0, 1'b0, 1'b0, 0, 0, "R2");
        run_group(8'h9C, 8'h63, 2'd1, 1'b0, 1'b0, 1'b0, 0, 0, "R3");
        run_group(8'hAA, 8'h1E, 2'd2, 1'b0, 1'b0, 1'b0, 0, 0, "R4");
        run_group(8'hFF, 8'h55, 2'd2, 1'b0, 1'b0, 1'b0, 0, 0, "R6");
        run_group(8'h81, 8'h7E, 2'd3, 1'b0, 1'b0, 1'b0, 0, 0, "R5");
        run_group(8'hC3, 8'h42, 2'd0, 1'b1, 1'b0, 1'b0, 0, 0, "R7");
        run_group(8'h01, 8'h92, 2'd0, 1'b0, 1'b1, 1'b0, 0, 0, "R8");
        run_group(8'h81, 8'h01, 2'd0, 1'b1, 1'b1, 1'b0, 0, 0, "R8");
        for (int pr = 0; pr < 4; pr++) begin
            ext_prio_i = 2'(pr);
            run_group(8'hA3, 8'h5C, 2'd2, 1'b0, 1'b0, 1'b0, 100, 0, "R9");
            run_group(8'h77, 8'h88, 2'd3, 1'b0, 1'b0, 1'b0, 100, 0, "R9");
        end
        ext_prio_i = 2'd0;
        run_group(8'hF0, 8'h0F, 2'd0, 1'b0, 1'b0, 1'b0, 0, 100, "R11");
        lo_r = 6'd2; hi_r = 6'd4;
        for (int g = 0; g < 5; g++)
            run_group(8'hB4, 8'h2D, 2'd1, 1'b0, 1'b0, (g == 0), 0, 0, "R10");

        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < 8; i++) palette_i[i*8 +: 8] = 8'($urandom);
            bias_i = 5'($urandom); border_i = 8'($urandom);
            ext_prio_i = 2'($urandom);
            lo_r = 6'($urandom % 4); hi_r = 6'(lo_r + 6'($urandom % 6));
            run_group(8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom),
                      1'($urandom), (($urandom % 6) == 0), 25, 10, "R6");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule